// File: doc/BRIEF.md
# Serial Port Service Request and Receive Timeout Controller

This block produces the service requests of a synchronous serial port. It receives the transmit and receive FIFO threshold conditions and the receive overrun pulse from the serial datapath. From these it drives one maskable interrupt, one non-maskable interrupt and a DMA request for each direction. It also contains a receive idle timer. The timer flags words that have been left in the receive FIFO when no new data arrives and no software read drains them.

Software reaches the block through a small word-addressed register bus with four registers:

| Address | Register | Access |
|---|---|---|
| 0 | control: enables | read/write |
| 1 | timeout count | read/write |
| 2 | test: forces requests | read/write |
| 3 | status | read; bits 2 and 3 write-1-to-clear |

A bit set in the test register behaves like the real condition it stands for. It appears in status and drives the matching enabled request, and it keeps doing so until software clears it. A forced overrun is special: it is routed to the non-maskable interrupt. All request outputs are plain levels decoded from the block's registers and its status inputs. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `ser_svcreq_top`

## Requirements
- R1: After reset all four request outputs are low and every register reads 0.
- R2: With a nonzero count T in the timeout register (address 1, bits 23:0), status bit 2 sets after exactly T consecutive clocks in which the receive FIFO is not empty and `rx_act_i` is low. A clock with `rx_act_i` high, or a write to the timeout register, restarts the count from zero.
- R3: With a timeout count of 0, status bit 2 never sets, however long the receive FIFO stays non-empty.
- R4: The idle count does not advance while the receive FIFO is empty. Once status bit 2 is set it stays set until a write to status (address 3) with bit 2 = 1. Counting then resumes from zero.
- R5: Test register (address 2) bits 5, 6 and 7 force the transmit service, receive service and receive overrun conditions. Status bits 0, 1 and 3 read the forced value ORed with the real condition, for as long as the test bit stays set.
- R6: Test bit 7 drives `nmi_o` high for as long as it is set. It never raises either DMA request.
- R7: `irq_o` is the OR over i = 0 to 3 of status bit i AND control bit i. Control bit 0 enables transmit service, bit 1 receive service, bit 2 timeout and bit 3 overrun.
- R8: `tx_dreq_o` equals control bit 4 AND status bit 0. `rx_dreq_o` equals control bit 5 AND status bit 1. Both requests can be high together, and neither depends on the interrupt enables.
- R9: A pulse on `rx_ovr_i` sets status bit 3 until a status write with bit 3 = 1 clears it. This real overrun reaches only `irq_o` and never `nmi_o`.
- R10: Reserved bits are ignored on write and read as 0. This covers timeout register bits 31:24 and every test register bit other than 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| tx_svc_i | input | 1 | Transmit FIFO at or below its threshold |
| rx_svc_i | input | 1 | Receive FIFO at or above its threshold |
| rx_ovr_i | input | 1 | Receive overrun pulse |
| rx_act_i | input | 1 | Word received or receive FIFO read this clock |
| rx_nempty_i | input | 1 | Receive FIFO holds at least one word |
| irq_o | output | 1 | Maskable interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |
| tx_dreq_o | output | 1 | Transmit DMA request |
| rx_dreq_o | output | 1 | Receive DMA request |

## Verification
The request merge is swept over all 64 control settings, all 8 test register patterns and all 4 combinations of the real transmit and receive conditions. This separates a wrong enable bit, a swapped source and a missing OR with a forced bit, and it shows that DMA and interrupt gating are independent. The timer is exercised with counts 1 through 6. Each count is checked on every clock against the exact edge at which the flag must appear. The same counts are used for restarts after an activity pulse, for a flag held through extra clocks, for a write-1 clear, and for an empty FIFO. Together these detect off-by-one errors and a counter that ignores the FIFO level. A count of zero, the real versus forced overrun paths, and writes with every reserved bit set cover the remaining corner cases.

// File: rtl/ser_svc_pkg.sv
package ser_svc_pkg;
  localparam int NSRC  = 4;
  // source / status bit positions (also interrupt enable positions)
  localparam int ST_TX = 0;
  localparam int ST_RX = 1;
  localparam int ST_TO = 2;
  localparam int ST_OV = 3;
  // control register
  localparam int CTL_W     = 6;
  localparam int CTL_TX_DE = 4;
  localparam int CTL_RX_DE = 5;
  // test register bit positions
  localparam int TST_TX = 5;
  localparam int TST_RX = 6;
  localparam int TST_OV = 7;
  // register word addresses
  localparam int A_CTRL = 0;
  localparam int A_TOUT = 1;
  localparam int A_TEST = 2;
  localparam int A_STAT = 3;

  function automatic logic [NSRC-1:0] test_to_src(input logic [7:0] b);
    logic [NSRC-1:0] v;
    v        = '0;
    v[ST_TX] = b[TST_TX];
    v[ST_RX] = b[TST_RX];
    v[ST_OV] = b[TST_OV];
    return v;
  endfunction
endpackage

// File: rtl/ser_svc_regs.sv
module ser_svc_regs
  import ser_svc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int TOUT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_ovr_i,
  input  logic [NSRC-1:0]   stat_eff,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic [TOUT_W-1:0] tout_o,
  output logic              tout_wr_o,
  output logic [NSRC-1:0]   frc_o,
  output logic              ov_real_o,
  output logic              to_clr_o
);
  logic wr_ctrl, wr_test, wr_stat, clr_ov;
  logic [CTL_W-1:0]  ctrl_q;
  logic [TOUT_W-1:0] tout_q;
  logic [NSRC-1:0]   frc_q;
  logic              ov_q;

  assign wr_ctrl   = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign tout_wr_o = reg_we && (reg_addr == ADDR_W'(A_TOUT));
  assign wr_test   = reg_we && (reg_addr == ADDR_W'(A_TEST));
  assign wr_stat   = reg_we && (reg_addr == ADDR_W'(A_STAT));
  assign clr_ov    = wr_stat && reg_wdata[ST_OV];
  assign to_clr_o  = wr_stat && reg_wdata[ST_TO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tout_q <= '0;
      frc_q  <= '0;
      ov_q   <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q <= reg_wdata[CTL_W-1:0];
      if (tout_wr_o) tout_q <= reg_wdata[TOUT_W-1:0];
      if (wr_test)   frc_q  <= test_to_src(reg_wdata[7:0]);
      ov_q <= (ov_q & ~clr_ov) | rx_ovr_i;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      reg_rdata = DATA_W'(ctrl_q);
    end else if (reg_addr == ADDR_W'(A_TOUT)) begin
      reg_rdata = DATA_W'(tout_q);
    end else if (reg_addr == ADDR_W'(A_TEST)) begin
      reg_rdata[TST_TX] = frc_q[ST_TX];
      reg_rdata[TST_RX] = frc_q[ST_RX];
      reg_rdata[TST_OV] = frc_q[ST_OV];
    end else if (reg_addr == ADDR_W'(A_STAT)) begin
      reg_rdata = DATA_W'(stat_eff);
    end
  end

  assign ctrl_o    = ctrl_q;
  assign tout_o    = tout_q;
  assign frc_o     = frc_q;
  assign ov_real_o = ov_q;
endmodule

// File: rtl/ser_svc_timer.sv
module ser_svc_timer #(
  parameter int TOUT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TOUT_W-1:0] tout_val,
  input  logic              tout_wr,
  input  logic              rx_act,
  input  logic              rx_nempty,
  input  logic              flag_clr,
  output logic [TOUT_W-1:0] cnt_o,
  output logic              flag_o
);
  logic [TOUT_W-1:0] cnt_q;
  logic              flag_q;
  logic              restart, advance, hit;

  assign restart = rx_act || tout_wr || (tout_val == '0);
  assign advance = rx_nempty && !flag_q;
  assign hit     = (cnt_q == tout_val - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (flag_clr) flag_q <= 1'b0;
      if (restart) begin
        cnt_q <= '0;
      end else if (advance) begin
        if (hit) begin
          cnt_q  <= '0;
          flag_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/ser_svc_merge.sv
module ser_svc_merge
  import ser_svc_pkg::*;
(
  input  logic [NSRC-1:0]  real_i,
  input  logic [NSRC-1:0]  frc_i,
  input  logic [CTL_W-1:0] ctrl_i,
  output logic [NSRC-1:0]  stat_eff_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             tx_dreq_o,
  output logic             rx_dreq_o
);
  logic [NSRC-1:0] masked;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign stat_eff_o[i] = real_i[i] | frc_i[i];
    assign masked[i]     = stat_eff_o[i] & ctrl_i[i];
  end

  assign irq_o     = |masked;
  assign nmi_o     = frc_i[ST_OV];
  assign tx_dreq_o = ctrl_i[CTL_TX_DE] & stat_eff_o[ST_TX];
  assign rx_dreq_o = ctrl_i[CTL_RX_DE] & stat_eff_o[ST_RX];
endmodule

// File: rtl/ser_svcreq_top.sv
module ser_svcreq_top
  import ser_svc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int TOUT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_svc_i,
  input  logic              rx_svc_i,
  input  logic              rx_ovr_i,
  input  logic              rx_act_i,
  input  logic              rx_nempty_i,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              tx_dreq_o,
  output logic              rx_dreq_o
);
  logic [CTL_W-1:0]  ctrl;
  logic [TOUT_W-1:0] tout_val;
  logic [TOUT_W-1:0] tout_cnt;
  logic              tout_wr, tout_flag, to_clr, ov_real;
  logic [NSRC-1:0]   frc, real_src, stat_eff;

  ser_svc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOUT_W(TOUT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_ovr_i(rx_ovr_i),
    .stat_eff(stat_eff), .ctrl_o(ctrl), .tout_o(tout_val),
    .tout_wr_o(tout_wr), .frc_o(frc), .ov_real_o(ov_real), .to_clr_o(to_clr)
  );

  ser_svc_timer #(.TOUT_W(TOUT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tout_val(tout_val), .tout_wr(tout_wr),
    .rx_act(rx_act_i), .rx_nempty(rx_nempty_i), .flag_clr(to_clr),
    .cnt_o(tout_cnt), .flag_o(tout_flag)
  );

  always_comb begin
    real_src        = '0;
    real_src[ST_TX] = tx_svc_i;
    real_src[ST_RX] = rx_svc_i;
    real_src[ST_TO] = tout_flag;
    real_src[ST_OV] = ov_real;
  end

  ser_svc_merge u_merge (
    .real_i(real_src), .frc_i(frc), .ctrl_i(ctrl), .stat_eff_o(stat_eff),
    .irq_o(irq_o), .nmi_o(nmi_o), .tx_dreq_o(tx_dreq_o), .rx_dreq_o(rx_dreq_o)
  );
endmodule

// File: rtl/ser_svc_chk.sv
module ser_svc_chk
  import ser_svc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int TOUT_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq_o,
  input logic              nmi_o,
  input logic              tx_dreq_o,
  input logic              rx_dreq_o,
  input logic [TOUT_W-1:0] tout_val,
  input logic [TOUT_W-1:0] tout_cnt,
  input logic              tout_flag,
  input logic [NSRC-1:0]   stat_eff
);
  logic stat_to_clr, test_ov_wr;
  assign stat_to_clr = reg_we && (reg_addr == ADDR_W'(A_STAT)) && reg_wdata[ST_TO];
  assign test_ov_wr  = reg_we && (reg_addr == ADDR_W'(A_TEST)) && reg_wdata[TST_OV];

  p_cnt_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_val != '0) |-> (tout_cnt < tout_val));
  p_zero_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_val == '0 && !tout_flag) |=> !tout_flag);
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tout_flag && !stat_to_clr) |=> tout_flag);
  p_nmi_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(test_ov_wr));
  p_irq_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (stat_eff != '0));
  p_tx_dreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dreq_o |-> stat_eff[ST_TX]);
  p_rx_dreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dreq_o |-> stat_eff[ST_RX]);
endmodule

bind ser_svcreq_top ser_svc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOUT_W(TOUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .nmi_o(nmi_o), .tx_dreq_o(tx_dreq_o),
  .rx_dreq_o(rx_dreq_o), .tout_val(tout_val), .tout_cnt(tout_cnt),
  .tout_flag(tout_flag), .stat_eff(stat_eff)
);

// File: tb/ser_svcreq_top_bench.sv
`timescale 1ns/100ps
module ser_svcreq_top_bench;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic tx_svc = 1'b0, rx_svc = 1'b0, rx_ovr = 1'b0, rx_act = 1'b0, rx_ne = 1'b0;
  logic irq, nmi, txd, rxd;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ser_svcreq_top u_ser_svcreq_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_svc_i(tx_svc),
    .rx_svc_i(rx_svc), .rx_ovr_i(rx_ovr), .rx_act_i(rx_act),
    .rx_nempty_i(rx_ne), .irq_o(irq), .nmi_o(nmi), .tx_dreq_o(txd), .rx_dreq_o(rxd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    #1;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 outputs", {28'd0, irq, nmi, txd, rxd}, 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      chk("R1 register", v, 32'd0);
    end

    // R5 R6 R7 R8: exhaustive merge sweep
    for (int c = 0; c < 64; c++) begin
      wr(0, 32'(c));
      for (int t = 0; t < 8; t++) begin
        wr(2, 32'(t) << 5);
        for (int r = 0; r < 4; r++) begin
          logic etx, erx, eov, eirq;
          @(negedge clk);
          tx_svc = r[0]; rx_svc = r[1];
          #1;
          etx  = r[0] | t[0];
          erx  = r[1] | t[1];
          eov  = t[2];
          eirq = (etx & c[0]) | (erx & c[1]) | (eov & c[3]);
          chk("R7 irq", {31'd0, irq}, {31'd0, eirq});
          chk("R6 nmi", {31'd0, nmi}, {31'd0, eov});
          chk("R8 tx dreq", {31'd0, txd}, {31'd0, etx & c[4]});
          chk("R8 rx dreq", {31'd0, rxd}, {31'd0, erx & c[5]});
          rd(3, v);
          chk("R5 status", v, {28'd0, eov, 1'b0, erx, etx});
        end
      end
    end
    @(negedge clk);
    tx_svc = 0; rx_svc = 0;
    wr(2, 0);
    wr(0, 32'h04);

    // R2 R4 timeout with counts 1..6
    for (int T = 1; T <= 6; T++) begin
      wr(1, 32'(T));
      @(negedge clk); rx_ne = 1'b1;
      for (int k = 1; k <= T; k++) begin
        @(negedge clk); #1;
        chk("R2 flag edge", {31'd0, irq}, {31'd0, k == T});
      end
      repeat (3) @(negedge clk);
      #1;
      chk("R4 flag held", {31'd0, irq}, 32'd1);
      rd(3, v);
      chk("R2 status bit2", v, 32'h4);
      wr(3, 32'h4);
      chk("R4 w1c clear", {31'd0, irq}, 32'd0);
      for (int k = 1; k <= T; k++) begin
        @(negedge clk); #1;
        chk("R4 resume", {31'd0, irq}, {31'd0, k == T});
      end
      wr(3, 32'h4);
      repeat (T - 1) @(negedge clk);
      rx_act = 1'b1;
      @(negedge clk); rx_act = 1'b0;
      #1;
      chk("R2 restart", {31'd0, irq}, 32'd0);
      for (int k = 1; k <= T; k++) begin
        @(negedge clk); #1;
        chk("R2 after activity", {31'd0, irq}, {31'd0, k == T});
      end
      rx_ne = 1'b0;
      wr(3, 32'h4);
      repeat (20) @(negedge clk);
      #1;
      chk("R4 empty fifo", {31'd0, irq}, 32'd0);
    end

    // R3 zero count
    wr(1, 0);
    @(negedge clk); rx_ne = 1'b1;
    repeat (40) @(negedge clk);
    #1;
    chk("R3 irq", {31'd0, irq}, 32'd0);
    rd(3, v);
    chk("R3 status", v, 32'd0);
    rx_ne = 1'b0;

    // R10 reserved bits
    wr(1, 32'hFF00_0005);
    rd(1, v);
    chk("R10 timeout", v, 32'h5);
    wr(2, 32'hFFFF_FF1F);
    rd(2, v);
    chk("R10 test low", v, 32'h0);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v);
    chk("R10 test all", v, 32'hE0);
    wr(2, 0);
    wr(1, 0);

    // R9 real overrun
    wr(0, 32'h38);
    @(negedge clk); rx_ovr = 1'b1;
    @(negedge clk); rx_ovr = 1'b0;
    #1;
    chk("R9 irq", {31'd0, irq}, 32'd1);
    chk("R9 nmi", {31'd0, nmi}, 32'd0);
    chk("R9 no dma", {30'd0, txd, rxd}, 32'd0);
    rd(3, v);
    chk("R9 status", v, 32'h8);
    wr(3, 32'h8);
    chk("R9 cleared", {31'd0, irq}, 32'd0);

    // R5 R6 forced overrun survives a clear
    wr(2, 32'h80);
    chk("R6 nmi forced", {31'd0, nmi}, 32'd1);
    chk("R6 no dma", {30'd0, txd, rxd}, 32'd0);
    wr(3, 32'h8);
    rd(3, v);
    chk("R5 forced holds", v, 32'h8);
    wr(2, 0);
    rd(3, v);
    chk("R5 released", v, 32'h0);
    chk("R6 nmi released", {31'd0, nmi}, 32'd0);

    finish_run();
  end
endmodule